// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block keeps an asynchronous DRAM of 1024 rows alive on behalf of a main memory controller. It never drives a row address. Every refresh it performs uses the column-strobe-first method: it lowers the column strobe, then the row strobe. The DRAM then chooses the row from its own internal counter, and the data pins stay idle.

After reset the sequencer waits through a start-up pause of programmable length. It then asks for the bus eight times in a row and issues one refresh cycle for each grant. Only after that does it report the memory as initialised, and the main controller must hold off its own traffic until then. From that point a free-running interval timer adds one owed refresh every `INTERVAL_CYC` clocks. The default of 1900 cycles at 125 MHz sits a little under 16 ms / 1024. While any refresh is owed, `refreshReq` stays high. Each grant taken while the sequencer is idle produces one complete strobe cycle.

The controller may postpone refreshes. If the number owed ever exceeds `PEND_LIMIT`, the deadline counts as missed. The sequencer then sets a sticky flag, drops `initDone`, and reruns the eight-cycle wake-up burst before normal operation resumes.

Top module: `dram_refresh_seq`

## Requirements
- R1: During reset and at its release, `rasN` and `casN` are 1, and `refreshReq`, `initDone` and `deadlineMiss` are 0.
- R2: After reset is released, `refreshReq` stays 0 for the first `PAUSE_CYC - 1` rising edges and is first seen high after edge `PAUSE_CYC`. No strobe moves before that, whatever `refreshGnt` does.
- R3: The wake-up burst consists of exactly `WAKE_CYC` (8) strobe cycles. `initDone` rises on the same edge on which the last of them ends.
- R4: A strobe cycle lasts `T_CSR + T_RAS + T_RP` clocks:
  - `casN` is low alone for `T_CSR` clocks.
  - `rasN` is then low for `T_RAS` clocks, with `casN` still low for the first `T_CHR` of them.
  - Both strobes are high for the final `T_RP` clocks.
  - `casN` is therefore low when `rasN` falls and high when `rasN` rises.
- R5: A strobe cycle starts on the edge after which `refreshGnt` was 1 while `refreshReq` was 1 and no cycle was running. A grant at any other time changes nothing at the ports.
- R6: Once `initDone` is high, the interval timer adds one owed refresh every `INTERVAL_CYC` clocks. The first is added `INTERVAL_CYC` edges after `initDone` rises. `refreshReq` is 1 in normal operation exactly while at least one refresh is owed.
- R7: A granted request stays asserted until its strobe cycle completes. It falls after the completing edge only if nothing else is then owed.
- R8: When an interval tick and the completion of a refresh cycle fall on the same edge, the owed count is left unchanged.
- R9: If the owed count would exceed `PEND_LIMIT`:
  - `deadlineMiss` is set and stays set until reset.
  - The owed count is cleared.
  - `initDone` falls and `refreshReq` is raised.
  - The eight-cycle wake-up burst is repeated before `initDone` rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| refreshGnt | input | 1 | Bus grant from the main controller |
| refreshReq | output | 1 | Bus request: a wake-up or refresh cycle is wanted |
| rasN | output | 1 | Row strobe to the DRAM, active low |
| casN | output | 1 | Column strobe to the DRAM, active low |
| initDone | output | 1 | Pause and wake-up burst complete; host traffic allowed |
| deadlineMiss | output | 1 | Sticky: the owed-refresh limit was exceeded |

## Verification
The interval tick and the completion of a strobe cycle can land on the same clock edge. When they do, the owed count must take the increment and the decrement together and stay where it was.

The bench provokes this by holding off the grant while one refresh is owed. It then issues a single grant at the exact timer phase that places the cycle's final edge on the next tick. At that point the request must still be high and the reference model's owed count must still be one.

The same per-clock comparison of every output against the behavioural model also covers the case where a grant and a tick arrive together.

// File: rtl/dram_refresh_pkg.sv
package dram_refresh_pkg;

  typedef enum logic [1:0] {
    ST_PAUSE = 2'd0,
    ST_WAKE  = 2'd1,
    ST_RUN   = 2'd2
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic startCycle;
    logic runTimer;
    logic clrTimer;
  } ctlStrobes_t;

  // status from datapath to control
  typedef struct packed {
    logic cycleDone;
    logic tick;
    logic busy;
  } dpStatus_t;

endpackage

// File: rtl/refresh_datapath.sv
module refresh_datapath
  import dram_refresh_pkg::*;
#(
  parameter int INTERVAL_CYC = 1900,
  parameter int T_CSR        = 2,
  parameter int T_CHR        = 2,
  parameter int T_RAS        = 8,
  parameter int T_RP         = 5
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctlStrobes_t ctl,
  output dpStatus_t   dpStat,
  output logic        rasN,
  output logic        casN
);

  localparam int SEQ_LEN = T_CSR + T_RAS + T_RP;
  localparam int SEQ_W   = $clog2(SEQ_LEN);
  localparam int IV_W    = $clog2(INTERVAL_CYC);
  localparam logic [SEQ_W-1:0] SEQ_LAST = SEQ_W'(SEQ_LEN - 1);
  localparam logic [SEQ_W-1:0] RAS_ON   = SEQ_W'(T_CSR);
  localparam logic [SEQ_W-1:0] RAS_OFF  = SEQ_W'(T_CSR + T_RAS);
  localparam logic [SEQ_W-1:0] CAS_OFF  = SEQ_W'(T_CSR + T_CHR);
  localparam logic [IV_W-1:0]  IV_LAST  = IV_W'(INTERVAL_CYC - 1);

  // interval timer
  logic [IV_W-1:0] ivCnt;
  logic            tickNow;

  assign tickNow = ctl.runTimer && (ivCnt == IV_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ivCnt <= '0;
    end else if (ctl.clrTimer) begin
      ivCnt <= '0;
    end else if (ctl.runTimer) begin
      ivCnt <= tickNow ? '0 : ivCnt + 1'b1;
    end
  end

  // strobe sequencer
  logic             busy;
  logic [SEQ_W-1:0] seqCnt;
  logic             busyNext;
  logic [SEQ_W-1:0] seqNext;
  logic             lastStep;

  assign lastStep = busy && (seqCnt == SEQ_LAST);

  always_comb begin
    busyNext = busy;
    seqNext  = seqCnt;
    if (!busy) begin
      if (ctl.startCycle) begin
        busyNext = 1'b1;
        seqNext  = '0;
      end
    end else if (lastStep) begin
      busyNext = 1'b0;
      seqNext  = '0;
    end else begin
      seqNext = seqCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy   <= 1'b0;
      seqCnt <= '0;
      rasN   <= 1'b1;
      casN   <= 1'b1;
    end else begin
      busy   <= busyNext;
      seqCnt <= seqNext;
      // strobes registered from the next-step position: glitch free
      rasN   <= !(busyNext && (seqNext >= RAS_ON) && (seqNext < RAS_OFF));
      casN   <= !(busyNext && (seqNext < CAS_OFF));
    end
  end

  assign dpStat.cycleDone = lastStep;
  assign dpStat.tick      = tickNow;
  assign dpStat.busy      = busy;

  // final step of each cycle lies in precharge
  assert_precharge_end_R4: assert property (@(posedge clk) disable iff (!rstN)
    lastStep |-> (rasN && casN));

  // a new cycle never begins on top of a running one
  assert_no_restart_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !lastStep) |=> busy);

endmodule

// File: rtl/refresh_ctrl.sv
module refresh_ctrl
  import dram_refresh_pkg::*;
#(
  parameter int PAUSE_CYC  = 25000,
  parameter int WAKE_CYC   = 8,
  parameter int PEND_LIMIT = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        refreshGnt,
  input  dpStatus_t   dpStat,
  output ctlStrobes_t ctl,
  output logic        refreshReq,
  output logic        initDone,
  output logic        deadlineMiss
);

  localparam int PAUSE_W = $clog2(PAUSE_CYC);
  localparam int WAKE_W  = $clog2(WAKE_CYC + 1);
  localparam int PEND_W  = $clog2(PEND_LIMIT + 2);
  localparam logic [PAUSE_W-1:0] PAUSE_LAST = PAUSE_W'(PAUSE_CYC - 1);
  localparam logic [WAKE_W-1:0]  WAKE_LOAD  = WAKE_W'(WAKE_CYC);
  localparam logic [PEND_W:0]    PEND_MAX   = (PEND_W + 1)'(PEND_LIMIT);

  seqState_t          state;
  logic [PAUSE_W-1:0] pauseCnt;
  logic [WAKE_W-1:0]  wakeLeft;
  logic [PEND_W-1:0]  pending;
  logic               missQ;
  logic [PEND_W:0]    pendSum;
  logic               overflow;
  logic               wakeFinal;

  assign refreshReq = (state == ST_WAKE) || ((state == ST_RUN) && (pending != '0));
  assign initDone   = (state == ST_RUN);
  assign deadlineMiss = missQ;

  assign pendSum = {1'b0, pending}
                 + {{PEND_W{1'b0}}, dpStat.tick}
                 - {{PEND_W{1'b0}}, dpStat.cycleDone};
  assign overflow  = (state == ST_RUN) && (pendSum > PEND_MAX);
  assign wakeFinal = (state == ST_WAKE) && dpStat.cycleDone && (wakeLeft == WAKE_W'(1));

  assign ctl.startCycle = refreshReq && refreshGnt && !dpStat.busy;
  assign ctl.runTimer   = (state == ST_RUN);
  assign ctl.clrTimer   = wakeFinal;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_PAUSE;
      pauseCnt <= '0;
      wakeLeft <= '0;
      pending  <= '0;
      missQ    <= 1'b0;
    end else begin
      unique case (state)
        ST_PAUSE: begin
          if (pauseCnt == PAUSE_LAST) begin
            state    <= ST_WAKE;
            wakeLeft <= WAKE_LOAD;
          end else begin
            pauseCnt <= pauseCnt + 1'b1;
          end
        end
        ST_WAKE: begin
          if (wakeFinal) begin
            state   <= ST_RUN;
            pending <= '0;
          end else if (dpStat.cycleDone) begin
            wakeLeft <= wakeLeft - 1'b1;
          end
        end
        ST_RUN: begin
          if (overflow) begin
            state    <= ST_WAKE;
            wakeLeft <= WAKE_LOAD;
            pending  <= '0;
            missQ    <= 1'b1;
          end else begin
            pending <= pendSum[PEND_W-1:0];
          end
        end
        default: state <= ST_PAUSE;
      endcase
    end
  end

  assert_pending_bound_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN) |-> (pending <= PEND_W'(PEND_LIMIT)));

  assert_miss_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    missQ |=> missQ);

  assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (refreshReq && dpStat.busy && !dpStat.cycleDone) |=> refreshReq);

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import dram_refresh_pkg::*;
#(
  parameter int PAUSE_CYC    = 25000,
  parameter int WAKE_CYC     = 8,
  parameter int INTERVAL_CYC = 1900,
  parameter int PEND_LIMIT   = 8,
  parameter int T_CSR        = 2,
  parameter int T_CHR        = 2,
  parameter int T_RAS        = 8,
  parameter int T_RP         = 5
) (
  input  logic clk,
  input  logic rstN,
  input  logic refreshGnt,
  output logic refreshReq,
  output logic rasN,
  output logic casN,
  output logic initDone,
  output logic deadlineMiss
);

  ctlStrobes_t ctl;
  dpStatus_t   dpStat;

  refresh_ctrl #(
    .PAUSE_CYC (PAUSE_CYC),
    .WAKE_CYC  (WAKE_CYC),
    .PEND_LIMIT(PEND_LIMIT)
  ) ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .refreshGnt  (refreshGnt),
    .dpStat      (dpStat),
    .ctl         (ctl),
    .refreshReq  (refreshReq),
    .initDone    (initDone),
    .deadlineMiss(deadlineMiss)
  );

  refresh_datapath #(
    .INTERVAL_CYC(INTERVAL_CYC),
    .T_CSR       (T_CSR),
    .T_CHR       (T_CHR),
    .T_RAS       (T_RAS),
    .T_RP        (T_RP)
  ) dp_i (
    .clk   (clk),
    .rstN  (rstN),
    .ctl   (ctl),
    .dpStat(dpStat),
    .rasN  (rasN),
    .casN  (casN)
  );

  assert_cas_before_ras_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rasN) |-> (!casN && $past(!casN)));

  assert_cas_up_at_ras_rise_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rasN) |-> casN);

  assert_quiet_before_wake_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!initDone && !refreshReq) |-> (rasN && casN));

endmodule

// File: tb/dram_refresh_seq_tb.sv
`timescale 1ns/1ps
module dram_refresh_seq_tb_top;

  localparam int P   = 40;
  localparam int W   = 8;
  localparam int IV  = 60;
  localparam int LIM = 3;
  localparam int CSR = 2;
  localparam int CHR = 2;
  localparam int RAS = 4;
  localparam int RP  = 3;
  localparam int L   = CSR + RAS + RP;

  logic clk = 1'b0;
  logic rstN;
  logic refreshGnt;
  logic refreshReq, rasN, casN, initDone, deadlineMiss;

  always #4 clk = ~clk;

  dram_refresh_seq #(
    .PAUSE_CYC(P), .WAKE_CYC(W), .INTERVAL_CYC(IV), .PEND_LIMIT(LIM),
    .T_CSR(CSR), .T_CHR(CHR), .T_RAS(RAS), .T_RP(RP)
  ) dut_i (
    .clk(clk), .rstN(rstN), .refreshGnt(refreshGnt), .refreshReq(refreshReq),
    .rasN(rasN), .casN(casN), .initDone(initDone), .deadlineMiss(deadlineMiss)
  );

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model: 0 pause, 1 wake, 2 run
  int mState, mPc, mWl, mPend, mIc, mSeq, mCoinc;
  bit mBusy, mMiss;

  function automatic bit expReq();
    return (mState == 1) || (mState == 2 && mPend > 0);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mState = 0; mPc = 0; mWl = 0; mPend = 0; mIc = 0;
      mSeq = 0; mBusy = 0; mMiss = 0; mCoinc = 0;
    end else begin
      bit done, start, tick;
      int np;
      done  = mBusy && (mSeq == L - 1);
      start = expReq() && refreshGnt && !mBusy;
      tick  = (mState == 2) && (mIc == IV - 1);
      if (start) begin mBusy = 1; mSeq = 0; end
      else if (done) begin mBusy = 0; mSeq = 0; end
      else if (mBusy) mSeq++;
      case (mState)
        0: if (mPc == P - 1) begin mState = 1; mWl = W; end else mPc++;
        1: if (done) begin
             if (mWl == 1) begin mState = 2; mPend = 0; mIc = 0; end
             else mWl--;
           end
        default: begin
          mIc = (mIc == IV - 1) ? 0 : mIc + 1;
          if (tick && done) mCoinc++;
          np = mPend + int'(tick) - int'(done);
          if (np > LIM) begin mState = 1; mWl = W; mPend = 0; mMiss = 1; end
          else mPend = np;
        end
      endcase
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      bit eRas, eCas;
      eRas = !(mBusy && mSeq >= CSR && mSeq < CSR + RAS);
      eCas = !(mBusy && mSeq < CSR + CHR);
      chk(rasN == eRas, "R4 rasN", rasN, eRas);
      chk(casN == eCas, "R4 casN", casN, eCas);
      chk(refreshReq == expReq(), "R6/R7 refreshReq", refreshReq, expReq());
      chk(initDone == (mState == 2), "R3 initDone", initDone, mState == 2);
      chk(deadlineMiss == mMiss, "R9 deadlineMiss", deadlineMiss, mMiss);
    end
  end

  task automatic finish_run();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  task automatic count_wake(input string tag);
    int falls = 0;
    bit prev = 1;
    for (int k = 0; k < 600 && !initDone; k++) begin
      @(negedge clk);
      if (prev && !rasN) falls++;
      prev = rasN;
    end
    chk(falls == W, tag, falls, W);
    chk(initDone == 1, tag, initDone, 1);
  endtask

  initial begin
    int firstReq, sinceInit;
    bit quiet;
    rstN = 0; refreshGnt = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(rasN && casN && !refreshReq && !initDone && !deadlineMiss, "R1 reset outputs",
        {rasN, casN, refreshReq, initDone, deadlineMiss}, 5'b11000);
    refreshGnt = 1;   // R5: grant during pause must be ignored
    rstN = 1;
    // R2 start-up pause
    firstReq = -1; quiet = 1;
    for (int k = 1; k <= P + 20 && firstReq < 0; k++) begin
      @(negedge clk);
      if (refreshReq) firstReq = k;
      else if (!rasN || !casN) quiet = 0;
    end
    chk(firstReq == P, "R2 first request edge", firstReq, P);
    chk(quiet, "R2 strobes idle during pause", quiet, 1);
    // R3 wake-up burst
    count_wake("R3 wake burst");
    // R5 grant with nothing owed
    quiet = 1; sinceInit = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk); sinceInit++;
      if (!rasN || !casN || refreshReq) quiet = 0;
    end
    chk(quiet, "R5 grant without request ignored", quiet, 1);
    // R6 interval
    refreshGnt = 0;
    while (!refreshReq && sinceInit < 300) begin @(negedge clk); sinceInit++; end
    chk(sinceInit == IV, "R6 first tick after init", sinceInit, IV);
    // R8 tick coincides with cycle completion
    for (int k = 0; k < 200 && mIc != IV - 1 - L; k++) @(negedge clk);
    refreshGnt = 1;
    @(negedge clk); refreshGnt = 0;
    repeat (L) @(negedge clk);
    chk(mCoinc == 1, "R8 coincidence provoked", mCoinc, 1);
    chk(refreshReq == 1, "R8 request kept after tick+done", refreshReq, 1);
    chk(mPend == 1, "R8 owed count unchanged", mPend, 1);
    // R7 request holds until completion, then drops
    refreshGnt = 1;
    @(negedge clk); refreshGnt = 0;
    quiet = 1;
    for (int k = 0; k < L - 1; k++) begin
      @(negedge clk);
      if (!refreshReq) quiet = 0;
    end
    chk(quiet, "R7 request held through cycle", quiet, 1);
    @(negedge clk);
    chk(refreshReq == 0, "R7 request dropped after completion", refreshReq, 0);
    // R9 deadline miss
    for (int k = 0; k < 400 && initDone; k++) @(negedge clk);
    chk(!initDone && deadlineMiss && refreshReq, "R9 overflow reaction",
        {initDone, deadlineMiss, refreshReq}, 3'b011);
    refreshGnt = 1;
    count_wake("R9 wake burst rerun");
    chk(deadlineMiss == 1, "R9 flag sticky", deadlineMiss, 1);
    // mixed grant patterns
    for (int k = 0; k < 800; k++) begin
      @(negedge clk);
      refreshGnt = ($urandom % 3) == 0;
    end
    refreshGnt = 0;
    @(negedge clk);
    finish_run();
  end

endmodule